// File: doc/BRIEF.md
# Strobed Input Port with Service Request

This block is an 8-bit parallel input port that sits between a peripheral and a processor data bus. The peripheral raises a strobe. While the strobe is high, a holding register follows the peripheral data. When the strobe falls, the register keeps its value and an active-low service request flag goes low to tell the processor that a byte is waiting.

The processor answers with an input cycle. It selects the port by raising two select inputs together, and the port then drives the held byte onto the bus. When the selection ends, the port releases the bus and the request flag returns high. A strobe that falls during a selection updates the register and re-raises the request once that selection has ended. An active-low clear input resets the flag and the register.

The tri-state bus is modelled as a data output plus an output enable. All inputs are sampled by a system clock through two-flop synchronizers, and edges are found on the synchronized copies. Only the input-port configuration exists: a mode input held low enables it.

Top module: `strobed_in_port`

## Requirements
- R1: During and after a synchronous reset, `srq_n_o` is 1, `bus_oe_o` is 0, `bus_data_o` is 0x00 and the held byte is 0x00.
- R2: While the synchronized strobe is high, the holding register follows `pdata_i`. After the strobe's falling edge, later changes of `pdata_i` do not reach the register.
- R3: A falling edge of `strobe_i` while the port is not selected drives `srq_n_o` to 0 within 4 clock cycles.
- R4: When `sel_act_i` and `sel_qual_i` are both 1 (and `mode_i` is 0), `bus_oe_o` becomes 1 and `bus_data_o` carries the held byte within 4 clock cycles.
- R5: When only one of `sel_act_i` and `sel_qual_i` is 1, the port does not drive the bus: `bus_oe_o` stays 0.
- R6: When a selection ends and no strobe fell during it, `bus_oe_o` returns to 0 and `srq_n_o` returns to 1 within 4 clock cycles.
- R7: Holding `clear_n_i` at 0 forces `srq_n_o` to 1 and the held byte to 0x00.
- R8: If the strobe falls while the port is selected, the register takes the new byte and `srq_n_o` is 0 after the selection ends. The end of that selection does not cancel this request.
- R9: With `mode_i` at 1, strobes are ignored (neither the register nor `srq_n_o` changes) and `bus_oe_o` stays 0.
- R10: Whenever `bus_oe_o` is 0, `bus_data_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 1 | Configuration select; 0 enables the input port |
| pdata_i | input | 8 | Byte from the peripheral |
| strobe_i | input | 1 | Peripheral strobe, active high; the falling edge latches |
| sel_act_i | input | 1 | Active-high select from the processor |
| sel_qual_i | input | 1 | Qualifying select; must be 1 together with `sel_act_i` |
| clear_n_i | input | 1 | Clear, active low |
| bus_data_o | output | 8 | Bus data; reads 0x00 when not driven |
| bus_oe_o | output | 1 | Bus output enable (1 = driving) |
| srq_n_o | output | 1 | Service request, active low |

## Verification
The assertions check on every cycle that the bus reads zero while it is not driven and that a driven bus carries the held byte. They also check that the register stays unchanged with the strobe low, that a clear forces the flag high, that the configuration input blocks the bus, and that each fall of the request flag follows a strobe edge or the end of a selection. Only the bench scenarios show the end-to-end sequences. These are: tracking followed by freezing on the strobe edge, a request raised during a selection that survives the deselect, strobes ignored in the wrong mode, and a single select that does not drive the bus.

// File: rtl/strobed_in_port_pkg.sv
package strobed_in_port_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  // Control inputs gathered for synchronization; bit order fixed by the struct
  typedef struct packed {
    logic clr_n;
    logic sel_q;
    logic sel_a;
    logic stb;
  } ctl_t;

  localparam int unsigned CTL_W = $bits(ctl_t);

  // Idle values while reset is applied: strobe low, selects low, clear released
  localparam ctl_t CTL_IDLE = '{clr_n: 1'b1, sel_q: 1'b0, sel_a: 1'b0, stb: 1'b0};
endpackage

// File: rtl/sip_sync.sv
module sip_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sip_edge.sv
module sip_edge #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      assign rise[g] = lvl[g] & ~prev_q[g];
      assign fall[g] = ~lvl[g] & prev_q[g];
    end
  endgenerate
endmodule

// File: rtl/sip_hold.sv
module sip_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          load,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (load)  q <= d;
  end
endmodule

// File: rtl/sip_req.sv
module sip_req (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic stb_fall,
  input  logic sel_now,
  input  logic sel_fall,
  output logic srq_n
);
  logic srq_n_q, pend_q;
  logic srq_n_d, pend_d;

  always_comb begin
    srq_n_d = srq_n_q;
    pend_d  = pend_q;
    if (clr) begin
      srq_n_d = 1'b1;
      pend_d  = 1'b0;
    end else begin
      if (sel_fall) begin
        srq_n_d = ~pend_q;
        pend_d  = 1'b0;
      end
      if (stb_fall) begin
        if (sel_now) pend_d  = 1'b1;
        else         srq_n_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      srq_n_q <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      srq_n_q <= srq_n_d;
      pend_q  <= pend_d;
    end
  end

  assign srq_n = srq_n_q;
endmodule

// File: rtl/strobed_in_port.sv
module strobed_in_port
  import strobed_in_port_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_i,
  input  logic [DW-1:0] pdata_i,
  input  logic          strobe_i,
  input  logic          sel_act_i,
  input  logic          sel_qual_i,
  input  logic          clear_n_i,
  output logic [DW-1:0] bus_data_o,
  output logic          bus_oe_o,
  output logic          srq_n_o
);
  localparam int unsigned EDGE_W = 2;

  ctl_t ctl_raw, ctl_s;
  logic stb_s, sel_now, clr_act;
  logic [EDGE_W-1:0] edge_lvl, edge_rise, edge_fall;
  logic stb_fall, sel_fall;
  logic [DW-1:0] hold_q;
  logic [DW-1:0] bus_data_q;
  logic bus_oe_q;

  assign ctl_raw = '{clr_n: clear_n_i, sel_q: sel_qual_i, sel_a: sel_act_i, stb: strobe_i};

  sip_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s)
  );

  assign stb_s   = ctl_s.stb & ~mode_i;
  assign sel_now = ctl_s.sel_a & ctl_s.sel_q & ~mode_i;
  assign clr_act = ~ctl_s.clr_n;

  assign edge_lvl = {sel_now, stb_s};

  sip_edge #(.W(EDGE_W)) u_edge (
    .clk(clk), .rst(rst), .lvl(edge_lvl), .rise(edge_rise), .fall(edge_fall)
  );

  assign stb_fall = edge_fall[0];
  assign sel_fall = edge_fall[1];

  sip_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst(rst), .clr(clr_act), .load(stb_s), .d(pdata_i), .q(hold_q)
  );

  sip_req u_req (
    .clk(clk), .rst(rst), .clr(clr_act), .stb_fall(stb_fall),
    .sel_now(sel_now), .sel_fall(sel_fall), .srq_n(srq_n_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_oe_q   <= 1'b0;
      bus_data_q <= '0;
    end else begin
      bus_oe_q   <= sel_now;
      bus_data_q <= sel_now ? hold_q : '0;
    end
  end

  assign bus_oe_o   = bus_oe_q;
  assign bus_data_o = bus_data_q;

  logic unused_rise;
  assign unused_rise = ^edge_rise;
endmodule

// File: rtl/strobed_in_port_chk.sv
module strobed_in_port_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          mode_i,
  input logic [DW-1:0] bus_data_o,
  input logic          bus_oe_o,
  input logic          srq_n_o,
  input logic          stb_s,
  input logic          stb_fall,
  input logic          sel_fall,
  input logic          clr_act,
  input logic [DW-1:0] hold_q
);
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !bus_oe_o |-> bus_data_o == '0); // R10

  AST_BUS_HOLDS_BYTE: assert property (@(posedge clk) disable iff (rst)
    bus_oe_o |-> bus_data_o == $past(hold_q)); // R4

  AST_FROZEN_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!stb_s && !clr_act) |=> $stable(hold_q)); // R2

  AST_CLEAR_FORCES: assert property (@(posedge clk) disable iff (rst)
    clr_act |=> (srq_n_o && hold_q == '0)); // R7

  AST_MODE_BLOCKS_BUS: assert property (@(posedge clk) disable iff (rst)
    $past(mode_i) |-> !bus_oe_o); // R9

  AST_SRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(srq_n_o) |-> $past(stb_fall || sel_fall)); // R3
endmodule

bind strobed_in_port strobed_in_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .mode_i(mode_i), .bus_data_o(bus_data_o),
  .bus_oe_o(bus_oe_o), .srq_n_o(srq_n_o), .stb_s(stb_s),
  .stb_fall(stb_fall), .sel_fall(sel_fall), .clr_act(clr_act), .hold_q(hold_q)
);

// File: tb/strobed_in_port_tb.sv
module strobed_in_port_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       mode_i;
  logic [7:0] pdata_i;
  logic       strobe_i, sel_act_i, sel_qual_i, clear_n_i;
  logic [7:0] bus_data_o;
  logic       bus_oe_o, srq_n_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] model_byte;

  always #4 clk = ~clk;

  strobed_in_port u_dut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .pdata_i(pdata_i),
    .strobe_i(strobe_i), .sel_act_i(sel_act_i), .sel_qual_i(sel_qual_i),
    .clear_n_i(clear_n_i), .bus_data_o(bus_data_o), .bus_oe_o(bus_oe_o),
    .srq_n_o(srq_n_o)
  );

  function automatic logic [7:0] bus_expect(input logic oe, input logic [7:0] held);
    return oe ? held : 8'h00;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_strobe(input logic [7:0] val);
    pdata_i  = val;
    strobe_i = 1'b1;
    wait_cyc(5);
    strobe_i = 1'b0;
    wait_cyc(5);
    pdata_i = ~val;   // later data must not reach the register
    wait_cyc(4);
  endtask

  task automatic select(input logic on);
    sel_act_i  = on;
    sel_qual_i = on;
    wait_cyc(5);
  endtask

  task automatic read_check(input string req, input logic [7:0] exp);
    select(1'b1);
    check({req, " oe"}, 32'(bus_oe_o), 32'd1);
    check({req, " data"}, 32'(bus_data_o), 32'(bus_expect(1'b1, exp)));
    select(1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7331));
    rst = 1'b1; mode_i = 1'b0; pdata_i = 8'h00; strobe_i = 1'b0;
    sel_act_i = 1'b0; sel_qual_i = 1'b0; clear_n_i = 1'b1;
    wait_cyc(3);
    // R1: state held in reset
    check("R1 srq", 32'(srq_n_o), 32'd1);
    check("R1 oe", 32'(bus_oe_o), 32'd0);
    check("R1 data", 32'(bus_data_o), 32'd0);
    rst = 1'b0;
    wait_cyc(4);
    read_check("R1 held", 8'h00);
    check("R6 srq idle", 32'(srq_n_o), 32'd1);

    // R2: tracking while high, then frozen at the falling edge
    pdata_i = 8'h3C; strobe_i = 1'b1; wait_cyc(5);
    pdata_i = 8'hA5; wait_cyc(5);
    strobe_i = 1'b0; wait_cyc(5);
    pdata_i = 8'h11; wait_cyc(5);
    model_byte = 8'hA5;
    check("R3 srq low", 32'(srq_n_o), 32'd0);
    read_check("R2 frozen", model_byte);
    check("R6 srq high", 32'(srq_n_o), 32'd1);
    check("R6 oe low", 32'(bus_oe_o), 32'd0);

    // R5 and R10: a single select does not drive the bus
    pulse_strobe(8'h5A); model_byte = 8'h5A;
    sel_act_i = 1'b1; wait_cyc(5);
    check("R5 act only oe", 32'(bus_oe_o), 32'd0);
    check("R10 data", 32'(bus_data_o), 32'd0);
    sel_act_i = 1'b0; sel_qual_i = 1'b1; wait_cyc(5);
    check("R5 qual only oe", 32'(bus_oe_o), 32'd0);
    sel_qual_i = 1'b0; wait_cyc(5);
    check("R5 srq kept", 32'(srq_n_o), 32'd0);
    read_check("R4 held", model_byte);

    // R8: strobe falls during a selection
    pulse_strobe(8'h77);
    select(1'b1);
    check("R4 first", 32'(bus_data_o), 32'h77);
    pulse_strobe(8'hC3); model_byte = 8'hC3;
    check("R8 bus updated", 32'(bus_data_o), 32'hC3);
    select(1'b0);
    check("R8 srq after deselect", 32'(srq_n_o), 32'd0);
    read_check("R8 byte", model_byte);
    check("R8 served", 32'(srq_n_o), 32'd1);

    // R9: configuration input high
    mode_i = 1'b1; wait_cyc(3);
    pulse_strobe(8'h99);
    check("R9 srq", 32'(srq_n_o), 32'd1);
    select(1'b1);
    check("R9 oe", 32'(bus_oe_o), 32'd0);
    check("R9 data", 32'(bus_data_o), 32'd0);
    select(1'b0);
    mode_i = 1'b0; wait_cyc(3);
    read_check("R9 unchanged", model_byte);

    // R7: clear after a strobe
    pulse_strobe(8'hE1);
    check("R3 before clear", 32'(srq_n_o), 32'd0);
    clear_n_i = 1'b0; wait_cyc(5);
    check("R7 srq", 32'(srq_n_o), 32'd1);
    clear_n_i = 1'b1; wait_cyc(4);
    model_byte = 8'h00;
    read_check("R7 byte", model_byte);

    // Random strobe/read rounds
    for (int i = 0; i < 40; i++) begin
      logic [7:0] v;
      v = 8'($urandom);
      pulse_strobe(v);
      model_byte = v;
      check("R3 rand srq", 32'(srq_n_o), 32'd0);
      read_check("R4 rand", model_byte);
      check("R6 rand srq", 32'(srq_n_o), 32'd1);
      check("R10 rand data", 32'(bus_data_o), 32'(bus_expect(bus_oe_o, model_byte)));
    end

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule